// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Front End

This block is the bus-facing half of a 32K x 8 serial EEPROM. It watches the two-wire clock and data lines with the system clock and passes each line through a two-flop synchronizer. From the synchronized levels it finds Start and Stop conditions and the rising and falling edges of the bus clock. It then frames bits into bytes and acknowledges by pulling SDA low through an open-drain enable. The array, the page buffer and the timed write controller sit behind it.

A transaction opens with a control byte that carries a device type code, three chip-select bits and a read/write flag. If the byte selects this device, a write transaction continues with a two-byte word address and then any number of data bytes. Each data byte goes to the write controller together with its address. A read transaction fetches bytes from the array interface and shifts them out, most significant bit first, until the master withholds its acknowledge. A single 15-bit pointer serves both directions. It is loaded by the word address and advances after each byte forwarded or fetched. While the write controller reports busy, the block acknowledges nothing.

Top module: `sereep_bus_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and neither the write-byte strobe, the read request nor the write-end strobe is asserted.
- R2: SDA falling while SCL is high is a Start, and it begins control-byte reception from the first bit; a Start that arrives partway through a byte discards the partial byte.
- R3: A control byte is acknowledged (SDA driven low for the whole ninth SCL pulse) only when its bits 7..4 equal 1010 and its bits 3..1 equal dev_sel_i[2:0]; bit 0 = 1 selects read. A control byte that does not match gets no acknowledge, and all further bytes are ignored until the next Start.
- R4: For a write, the next two bytes are the high and then the low word address, and both are acknowledged; bit 7 of the high byte is ignored and the pointer is loaded with {high[6:0], low}.
- R5: Every write data byte is acknowledged and presented for one cycle on wr_byte_valid_o, with wr_byte_addr_o equal to the pointer; the pointer then advances by one and wraps from 7FFF to 0000.
- R6: SDA rising while SCL is high is a Stop; it returns the block to idle, and it pulses wr_stop_o for one cycle when at least one data byte was forwarded since the last Start.
- R7: When wr_busy_i is high as any byte completes, that byte gets no acknowledge and is not forwarded, and the block stays silent until the next Start.
- R8: After an acknowledged read control byte, the block issues rd_req_o for one cycle with rd_addr_o equal to the pointer, samples rd_data_i on the following cycle and shifts the byte out MSB first; the pointer advances after each fetch and wraps from 7FFF to 0000.
- R9: In a read, a master acknowledge (SDA low on the ninth pulse) fetches and sends the next byte; a missing acknowledge ends the transfer with SDA released until the next Start.
- R10: The SDA pull-down enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| dev_sel_i | input | 3 | Chip-select levels compared with control byte bits 3..1 |
| wr_busy_i | input | 1 | Write controller is running a programming cycle |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_byte_valid_o | output | 1 | One-cycle strobe for a received write data byte |
| wr_byte_addr_o | output | 15 | Address of the forwarded data byte |
| wr_byte_data_o | output | 8 | Forwarded data byte |
| wr_stop_o | output | 1 | One-cycle strobe: a write transaction ended with a Stop |
| rd_req_o | output | 1 | One-cycle request to read the array at rd_addr_o |
| rd_addr_o | output | 15 | Current pointer, used as the read address |
| rd_data_i | input | 8 | Array byte, valid the cycle after rd_req_o |

## Verification
Two decisions fall at the same byte-end edge. One is whether to acknowledge, since the busy input can veto it. The other is whether to forward the byte to the write controller. The bench raises wr_busy_i after an addressed write has had both address bytes acknowledged, then sends a data byte, so the busy veto and the forward fall on the same SCL edge. It judges the case by a missing acknowledge, an empty write scoreboard and no write-end strobe at the following Stop. A second meeting point is a Start that lands partway through a control byte while the bit shifter is filling. This is provoked with three stray bits and judged by a clean read that follows at once.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } slv_state_t;

  // control byte selects this device: type code in [7:4], select in [3:1]
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [3:0] code,
                                    input logic [2:0] sel);
    return (b[7:4] == code) && (b[3:1] == sel);
  endfunction

endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sereep_cond_det.sv
module sereep_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sereep_addr_ptr.sv
module sereep_addr_ptr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_next(ptr_o);
  end

  // R5 / R8: each advance is exactly one step, wrapping at the top
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> (ptr_o == ptr_next($past(ptr_o))));
endmodule

// File: rtl/sereep_bus_slave.sv
module sereep_bus_slave #(
  parameter int         ADDR_W      = 15,
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel_i,
  input  logic              wr_busy_i,
  output logic              sda_oe_o,
  output logic              wr_byte_valid_o,
  output logic [ADDR_W-1:0] wr_byte_addr_o,
  output logic [7:0]        wr_byte_data_o,
  output logic              wr_stop_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  import sereep_pkg::*;

  localparam int HI_KEEP = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[HI_KEEP-1:0], lo};
  endfunction

  logic scl_lvl, sda_lvl;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] ptr;

  sereep_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_lvl, sda_lvl}));

  sereep_cond_det i_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_lvl), .sda_s(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt));

  slv_state_t state;
  logic [3:0] cnt;
  logic [7:0] rx_sh, tx_sh, hi_q, rd_byte;
  logic       rw_q, wr_any, fetch_pend;

  logic rx_state, rx_end, ack_ok, load_now;
  assign rx_state = (state == ST_CTRL) || (state == ST_AHI) ||
                    (state == ST_ALO)  || (state == ST_WDAT);
  assign rx_end   = rx_state && scl_fall && (cnt == 4'd8);
  assign ack_ok   = !wr_busy_i &&
                    ((state != ST_CTRL) || ctrl_hit(rx_sh, TYPE_CODE, dev_sel_i));
  assign load_now = rx_end && ack_ok && (state == ST_ALO);

  sereep_addr_ptr #(.ADDR_W(ADDR_W)) i_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(load_now), .load_val_i(word_addr(hi_q, rx_sh)),
    .inc_i(rd_req_o | wr_byte_valid_o), .ptr_o(ptr));

  assign rd_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; rx_sh <= '0; tx_sh <= '0; hi_q <= '0;
      rd_byte <= '0; rw_q <= 1'b0; wr_any <= 1'b0; fetch_pend <= 1'b0;
      sda_oe_o <= 1'b0; wr_byte_valid_o <= 1'b0; wr_byte_addr_o <= '0;
      wr_byte_data_o <= '0; wr_stop_o <= 1'b0; rd_req_o <= 1'b0;
    end else begin
      rd_req_o        <= 1'b0;
      wr_byte_valid_o <= 1'b0;
      wr_stop_o       <= 1'b0;
      fetch_pend      <= rd_req_o;
      if (fetch_pend) rd_byte <= rd_data_i;

      if (start_evt) begin
        state <= ST_CTRL; cnt <= '0; sda_oe_o <= 1'b0; wr_any <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE; cnt <= '0; sda_oe_o <= 1'b0;
        wr_stop_o <= wr_any; wr_any <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (state == ST_RDAT) begin
            if (cnt == 4'd8) begin
              if (sda_lvl) state <= ST_IDLE;   // master withheld its acknowledge
              else         rd_req_o <= 1'b1;
            end
          end else if (cnt < 4'd8) begin
            rx_sh <= {rx_sh[6:0], sda_lvl};
          end
        end
        if (scl_fall) begin
          if (rx_state) begin
            if (cnt == 4'd8) begin
              if (ack_ok) begin
                sda_oe_o <= 1'b1;
                case (state)
                  ST_CTRL: begin
                    rw_q <= rx_sh[0];
                    if (rx_sh[0]) rd_req_o <= 1'b1;
                  end
                  ST_AHI:  hi_q <= rx_sh;
                  ST_WDAT: begin
                    wr_byte_valid_o <= 1'b1;
                    wr_byte_addr_o  <= ptr;
                    wr_byte_data_o  <= rx_sh;
                    wr_any          <= 1'b1;
                  end
                  default: ;
                endcase
              end else begin
                state <= ST_IDLE;
              end
            end else if (cnt == 4'd9) begin
              sda_oe_o <= 1'b0;
              cnt      <= '0;
              case (state)
                ST_CTRL: begin
                  if (rw_q) begin
                    state    <= ST_RDAT;
                    sda_oe_o <= ~rd_byte[7];
                    tx_sh    <= {rd_byte[6:0], 1'b0};
                  end else begin
                    state <= ST_AHI;
                  end
                end
                ST_AHI:  state <= ST_ALO;
                default: state <= ST_WDAT;
              endcase
            end
          end else begin
            if (cnt == 4'd9) begin
              cnt      <= '0;
              sda_oe_o <= ~rd_byte[7];
              tx_sh    <= {rd_byte[6:0], 1'b0};
            end else if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
            end else if (cnt != 4'd0) begin
              sda_oe_o <= ~tx_sh[7];
              tx_sh    <= {tx_sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  // R10: the pull-down only moves while the bus clock is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_lvl);
  // R7: a byte finishing under busy is never acknowledged
  a_r7_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && wr_busy_i) |=> (!sda_oe_o && !wr_byte_valid_o));
  // R2: a Start restarts framing with the line released
  a_r2_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_CTRL && cnt == 4'd0 && !sda_oe_o));
  // R6: a Stop always returns to idle
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE));
  // R8: a read request is a single-cycle pulse and never meets a write strobe
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> (!rd_req_o && $onehot0({rd_req_o, wr_byte_valid_o})));
endmodule

// File: tb/test_sereep_bus_slave.sv
`timescale 1ns/1ps
module test_sereep_bus_slave;
  localparam int Q = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wr_busy = 1'b0;
  logic sda_oe, wr_valid, wr_stop, rd_req;
  logic [14:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  sereep_bus_slave i_sereep_bus_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .dev_sel_i(SEL),
    .wr_busy_i(wr_busy), .sda_oe_o(sda_oe), .wr_byte_valid_o(wr_valid),
    .wr_byte_addr_o(wr_addr), .wr_byte_data_o(wr_data), .wr_stop_o(wr_stop),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  int checks = 0, fails = 0, stops = 0, r10_bad = 0;
  logic [22:0] sb_q[$];

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  // array model: data valid the cycle after the request
  always @(posedge clk) if (rd_req) rd_data <= pat(rd_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for forwarded write bytes (R5)
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (wr_valid) begin
      if (sb_q.size() == 0) chk(1'b0, "R5", "unexpected write byte", {wr_addr, wr_data}, 0);
      else begin
        logic [22:0] e;
        e = sb_q.pop_front();
        chk({wr_addr, wr_data} == e, "R5", "write byte addr/data", {wr_addr, wr_data}, e);
      end
    end
    if (wr_stop) stops++;
    if (rst_n && sda_oe != oe_prev && m_scl) r10_bad++;
    oe_prev = sda_oe;
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); acked = !sda_bus; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); m_scl = 1; wq(Q); b = {b[6:0], sda_bus}; wq(Q); m_scl = 0; wq(Q);
    end
    m_sda = mack ? 1'b0 : 1'b1; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q); m_sda = 1;
  endtask

  initial begin
    bit a;
    logic [7:0] rb;
    int s0;
    rd_data = 8'h00;
    wq(5);
    chk(sda_oe == 0 && wr_valid == 0 && rd_req == 0 && wr_stop == 0, "R1",
        "outputs after reset", {sda_oe, wr_valid, rd_req, wr_stop}, 0);
    rst_n = 1; wq(10);

    // byte write at 1234
    bus_start;
    send_byte({4'b1010, SEL, 1'b0}, a); chk(a, "R3", "control write ack", a, 1);
    send_byte(8'h12, a); chk(a, "R4", "addr high ack", a, 1);
    send_byte(8'h34, a); chk(a, "R4", "addr low ack", a, 1);
    sb_q.push_back({15'h1234, 8'h5C});
    send_byte(8'h5C, a); chk(a, "R5", "data ack", a, 1);
    bus_stop; wq(4);
    chk(stops == 1, "R6", "write-end strobe count", stops, 1);
    chk(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);

    // current-address read continues after the written byte
    bus_start;
    send_byte({4'b1010, SEL, 1'b1}, a); chk(a, "R3", "control read ack", a, 1);
    recv_byte(1'b0, rb); chk(rb == pat(15'h1235), "R8", "read after write", rb, pat(15'h1235));
    wq(Q); chk(sda_oe == 0, "R9", "released after master nack", sda_oe, 0);
    bus_stop;

    // random sequential read across the top; high bit 7 ignored
    bus_start;
    send_byte({4'b1010, SEL, 1'b0}, a);
    send_byte(8'hFF, a); send_byte(8'hFE, a);
    bus_start;
    send_byte({4'b1010, SEL, 1'b1}, a); chk(a, "R2", "repeated start read ack", a, 1);
    recv_byte(1'b1, rb); chk(rb == pat(15'h7FFE), "R4", "masked high byte", rb, pat(15'h7FFE));
    recv_byte(1'b1, rb); chk(rb == pat(15'h7FFF), "R9", "master ack continues", rb, pat(15'h7FFF));
    recv_byte(1'b0, rb); chk(rb == pat(15'h0000), "R8", "read wrap", rb, pat(15'h0000));
    bus_stop; wq(4);
    chk(stops == 1, "R6", "no strobe without data", stops, 1);

    // multi-byte write across the top of the space
    bus_start;
    send_byte({4'b1010, SEL, 1'b0}, a);
    send_byte(8'h7F, a); send_byte(8'hFF, a);
    sb_q.push_back({15'h7FFF, 8'h11}); send_byte(8'h11, a);
    sb_q.push_back({15'h0000, 8'h22}); send_byte(8'h22, a);
    sb_q.push_back({15'h0001, 8'h33}); send_byte(8'h33, a);
    chk(a, "R5", "last data ack", a, 1);
    bus_stop; wq(4);
    chk(stops == 2, "R6", "second write-end strobe", stops, 2);
    chk(sb_q.size() == 0, "R5", "wrap writes drained", sb_q.size(), 0);

    // wrong chip select and wrong type code
    bus_start;
    send_byte({4'b1010, 3'b100, 1'b0}, a); chk(!a, "R3", "wrong select no ack", a, 0);
    send_byte(8'h00, a); chk(!a, "R3", "ignored after mismatch", a, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1011, SEL, 1'b0}, a); chk(!a, "R3", "wrong type no ack", a, 0);
    bus_stop;

    // busy at control byte, then busy arriving at a data byte
    wr_busy = 1;
    bus_start;
    send_byte({4'b1010, SEL, 1'b0}, a); chk(!a, "R7", "busy control no ack", a, 0);
    bus_stop;
    wr_busy = 0; s0 = stops;
    bus_start;
    send_byte({4'b1010, SEL, 1'b0}, a);
    send_byte(8'h01, a); send_byte(8'h00, a); chk(a, "R4", "addr ack before busy", a, 1);
    wr_busy = 1;
    send_byte(8'hEE, a); chk(!a, "R7", "busy data no ack", a, 0);
    bus_stop; wq(4); wr_busy = 0;
    chk(stops == s0, "R7", "no strobe after busy byte", stops, s0);
    chk(sb_q.size() == 0, "R7", "busy byte not forwarded", sb_q.size(), 0);

    // Start in the middle of a byte restarts framing
    bus_start;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_start;
    send_byte({4'b1010, SEL, 1'b1}, a); chk(a, "R2", "ack after mid-byte start", a, 1);
    recv_byte(1'b0, rb); chk(rb == pat(15'h0100), "R2", "read after abort", rb, pat(15'h0100));
    bus_stop; wq(4);

    chk(r10_bad == 0, "R10", "enable moved with SCL high", r10_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule